// File: doc/BRIEF.md
# Sensed External Interrupt Concentrator

This block takes up to 64 external interrupt wires, runs each through a two-flop synchronizer, and decides per source whether it is pending according to a sense mode held in that source's configuration. Sources whose two enable bits are both set take part in arbitration. The lowest-numbered pending source is reported in a status word. One registered request line goes up to a parent interrupt controller.

Software uses a word-wide register bus with a combinational read path. It controls a global detection gate, a request-output gate, and a stored level-mask word. It has a command register that clears edge latches. Each source has two configuration words, which also hold a target node field, a tag and a class for a parent to consume. Only sources 47 to 50 can latch edges or sense an active-low level. Every other source always behaves as active-high level.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the global detect gate and request gate are 0. Each source's first configuration word reads 0x01000000 (disabled, level high). The status word reads source 63 in bits 31:24, and `irq_req` is 0.
- R2: First configuration word (byte address 0x200 + 8·n): bits 29:28 enable, bits 25:24 sense, bits 7:4 node. Second word (address +4): bits 23:16 class, bits 7:0 tag. All other bits read as zero.
- R3: Outside sources 47..50 the sense field reads back as 1 whatever is written, and the source acts as active-high level.
- R4: Sense 1 means pending while the synchronized input is high. Sense 0 means pending while it is low.
- R5: Sense 3 latches a rising edge and sense 2 latches a falling edge. The latch stays set after the input returns.
- R6: A write to 0x0C0 with bit 8 set clears the edge latch of the edge-capable source whose number has bits 3:0 equal to the written bits 3:0. A write to 0x0C0 with bit 8 clear has no effect.
- R7: A source is arbitrated only when both enable bits are 1.
- R8: The status register at 0x144 gives the lowest-numbered pending enabled source in bits 31:24, or 63 when none is pending.
- R9: While bit 0 of 0x004 is 0, no source is pending and no edge is latched.
- R10: `irq_req` is a register that is set one cycle after a source is reported while bit 0 of 0x444 is 1, and is 0 one cycle after that bit is 0.
- R11: The word at 0x084 stores all 32 bits and reads them back. Its value does not change which source is reported.
- R12: An input change is seen at the status register two clock edges later for a level source and three edges later for an edge source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address; accesses with bits 1:0 nonzero are ignored |
| bus_we | input | 1 | Write strobe, one cycle per word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_in | input | 64 | External interrupt lines, asynchronous |
| irq_req | output | 1 | Request to the parent controller |

## Verification
A level input driven just after a falling edge appears in the status word after the second rising edge. An edge source appears after the third rising edge, and `irq_req` follows one edge after the status word. Register writes take effect at the rising edge inside the write task. The bench samples only at falling edges, and the timing test reads the status word at exactly one, two and three edges after the input change. The other tests wait five cycles before they compare, which is longer than the longest path.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int SRC_COUNT = 64;
  localparam int EDGE_FIRST = 47;
  localparam int EDGE_LAST = 50;
  typedef enum logic [1:0] {
    SENSE_LVL_LO = 2'd0,
    SENSE_LVL_HI = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_RISE   = 2'd3
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_out  <= '0;
    end else begin
      meta_q <= d_in;
      d_out  <= meta_q;
    end
  end
endmodule

// File: rtl/irq_detect.sv
module irq_detect
  import ext_irq_pkg::*;
#(
  parameter int NSRC = SRC_COUNT,
  parameter int E_LO = EDGE_FIRST,
  parameter int E_HI = EDGE_LAST
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      sync_in,
  input  logic                 det_en,
  input  logic [NSRC-1:0][1:0] sense,
  input  logic                 clr_valid,
  input  logic [3:0]           clr_low,
  output logic [NSRC-1:0]      pend
);
  for (genvar s = 0; s < NSRC; s++) begin : g_det
    logic latch;
    logic lvl_hit;
    assign lvl_hit = sense[s][0] ? sync_in[s] : ~sync_in[s];
    assign pend[s] = det_en & (sense[s][1] ? latch : lvl_hit);
    if (s >= E_LO && s <= E_HI) begin : g_edge
      localparam logic [3:0] LOWID = 4'(s);
      logic prev_q, latch_q, latch_d, set_c, clr_c;
      always_comb begin
        set_c = 1'b0;
        if (det_en) begin
          if (sense[s] == SENSE_RISE)      set_c = sync_in[s] & ~prev_q;
          else if (sense[s] == SENSE_FALL) set_c = ~sync_in[s] & prev_q;
        end
        clr_c   = clr_valid && (clr_low == LOWID);
        latch_d = sense[s][1] & (set_c | (latch_q & ~clr_c));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q  <= 1'b0;
          latch_q <= 1'b0;
        end else begin
          prev_q  <= sync_in[s];
          latch_q <= latch_d;
        end
      end
      assign latch = latch_q;
      // R9
      edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> $past(det_en));
      // R6
      edge_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && !set_c) |=> !latch_q);
    end else begin : g_lvl
      assign latch = 1'b0;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 64,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] act,
  output logic            found,
  output logic [IDW-1:0]  idx
);
  always_comb begin
    found = |act;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) idx = IDW'(i);
    end
  end
  // R8
  pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> act[idx]);
  // R8
  pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((act << (NSRC - int'(idx))) == '0));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NSRC = SRC_COUNT,
  parameter int E_LO = EDGE_FIRST,
  parameter int E_HI = EDGE_LAST
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     bus_addr,
  input  logic            bus_we,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic            irq_req
);
  localparam int IDW = $clog2(NSRC);
  localparam logic [IDW-1:0] IDLE_ID = IDW'(NSRC - 1);
  localparam logic [11:0] A_DET  = 12'h004;
  localparam logic [11:0] A_MASK = 12'h084;
  localparam logic [11:0] A_ECLR = 12'h0C0;
  localparam logic [11:0] A_STAT = 12'h144;
  localparam logic [11:0] A_PKT  = 12'h444;
  localparam logic [11:0] A_CFG  = 12'h200;

  logic aligned, is_cfg;
  logic [IDW-1:0] cfg_src;
  assign aligned = bus_addr[1:0] == 2'b00;
  assign is_cfg  = aligned && (bus_addr[11:IDW+3] == A_CFG[11:IDW+3]);
  assign cfg_src = bus_addr[IDW+2:3];

  // global control registers
  logic det_q, det_d, pkt_q, pkt_d, req_d;
  logic [31:0] mask_q, mask_d;
  logic found;
  logic [IDW-1:0] pick_idx, cs_id;

  always_comb begin
    det_d  = det_q;
    pkt_d  = pkt_q;
    mask_d = mask_q;
    if (bus_we && bus_addr == A_DET)  det_d  = bus_wdata[0];
    if (bus_we && bus_addr == A_PKT)  pkt_d  = bus_wdata[0];
    if (bus_we && bus_addr == A_MASK) mask_d = bus_wdata;
    req_d = pkt_q & found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q   <= 1'b0;
      pkt_q   <= 1'b0;
      mask_q  <= '0;
      irq_req <= 1'b0;
    end else begin
      det_q   <= det_d;
      pkt_q   <= pkt_d;
      mask_q  <= mask_d;
      irq_req <= req_d;
    end
  end

  // per-source configuration storage
  logic [NSRC-1:0][1:0] en_a, sense_a;
  logic [NSRC-1:0][3:0] node_a;
  logic [NSRC-1:0][7:0] tag_a, cls_a;
  logic [NSRC-1:0]      act;

  for (genvar s = 0; s < NSRC; s++) begin : g_cfg
    logic sel0, sel1;
    logic [1:0] en_q, en_d;
    logic [3:0] node_q, node_d;
    logic [7:0] tag_q, tag_d, cls_q, cls_d;
    assign sel0 = bus_we && is_cfg && cfg_src == IDW'(s) && !bus_addr[2];
    assign sel1 = bus_we && is_cfg && cfg_src == IDW'(s) &&  bus_addr[2];
    always_comb begin
      en_d   = sel0 ? bus_wdata[29:28] : en_q;
      node_d = sel0 ? bus_wdata[7:4]   : node_q;
      cls_d  = sel1 ? bus_wdata[23:16] : cls_q;
      tag_d  = sel1 ? bus_wdata[7:0]   : tag_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= '0;
        node_q <= '0;
        cls_q  <= '0;
        tag_q  <= '0;
      end else begin
        en_q   <= en_d;
        node_q <= node_d;
        cls_q  <= cls_d;
        tag_q  <= tag_d;
      end
    end
    if (s >= E_LO && s <= E_HI) begin : g_sns
      logic [1:0] sense_q, sense_d;
      assign sense_d = sel0 ? bus_wdata[25:24] : sense_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sense_q <= SENSE_LVL_HI;
        else        sense_q <= sense_d;
      end
      assign sense_a[s] = sense_q;
    end else begin : g_fix
      assign sense_a[s] = SENSE_LVL_HI;
    end
    assign en_a[s]   = en_q;
    assign node_a[s] = node_q;
    assign cls_a[s]  = cls_q;
    assign tag_a[s]  = tag_q;
  end

  // detection datapath
  logic [NSRC-1:0] sync_in, pend;

  irq_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(irq_in), .d_out(sync_in)
  );

  irq_detect #(.NSRC(NSRC), .E_LO(E_LO), .E_HI(E_HI)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .det_en(det_q),
    .sense(sense_a), .clr_valid(bus_we && bus_addr == A_ECLR && bus_wdata[8]),
    .clr_low(bus_wdata[3:0]), .pend(pend)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_act
    assign act[s] = pend[s] & (&en_a[s]);
  end

  irq_pick #(.NSRC(NSRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .act(act), .found(found), .idx(pick_idx)
  );

  assign cs_id = found ? pick_idx : IDLE_ID;

  // read path
  always_comb begin
    bus_rdata = '0;
    if (is_cfg) begin
      if (!bus_addr[2])
        bus_rdata = {2'b00, en_a[cfg_src], 2'b00, sense_a[cfg_src],
                     16'h0000, node_a[cfg_src], 4'h0};
      else
        bus_rdata = {8'h00, cls_a[cfg_src], 8'h00, tag_a[cfg_src]};
    end else begin
      case (bus_addr)
        A_DET:   bus_rdata = {31'd0, det_q};
        A_PKT:   bus_rdata = {31'd0, pkt_q};
        A_MASK:  bus_rdata = mask_q;
        A_STAT:  bus_rdata = {8'(cs_id), 24'd0};
        default: bus_rdata = '0;
      endcase
    end
  end

  // R9
  det_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_q |-> (cs_id == IDLE_ID));
  // R10
  req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_q |=> !irq_req);
  // R10
  req_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_q && found) |=> irq_req);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_in = '0;
  logic irq_req;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_cs(input string req, input int exp);
    logic [31:0] v;
    rd(12'h144, v);
    chk(req, {24'd0, v[31:24]}, exp);
  endtask

  function automatic logic [11:0] c0(input int s);
    return 12'(12'h200 + 8 * s);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk_cs("R1 status", 63);
    chk("R1 irq_req", {31'd0, irq_req}, 0);
    rd(c0(3), v);  chk("R1 cfg0 src3", v, 32'h0100_0000);
    rd(c0(48), v); chk("R1 cfg0 src48", v, 32'h0100_0000);
    rd(12'h004, v); chk("R1 detect gate", v, 0);
    rd(12'h444, v); chk("R1 request gate", v, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(c0(48), 32'hFFFF_FFFF);
    rd(c0(48), v); chk("R2 cfg0 fields", v, 32'h3300_00F0);
    wr(c0(48) + 12'd4, 32'hFFFF_FFFF);
    rd(c0(48) + 12'd4, v); chk("R2 cfg1 fields", v, 32'h00FF_00FF);
    wr(c0(48), 32'h0100_0000);
    rd(c0(48), v); chk("R2 cfg0 rewrite", v, 32'h0100_0000);
  endtask

  task automatic t_force();
    logic [31:0] v;
    wr(c0(10), 32'h3300_0000);
    rd(c0(10), v); chk("R3 forced sense", v, 32'h3100_0000);
    irq_in[10] = 1'b1; settle(); chk_cs("R3 acts as level high", 10);
    irq_in[10] = 1'b0; settle(); chk_cs("R3 no edge latch", 63);
    wr(c0(10), 0);
  endtask

  task automatic t_timing();
    wr(c0(7), 32'h3100_0000);
    @(negedge clk); bus_addr = 12'h144;
    irq_in[7] = 1'b1;
    @(negedge clk); #1 chk("R12 one edge", {24'd0, bus_rdata[31:24]}, 63);
    @(negedge clk); #1 chk("R12 two edges", {24'd0, bus_rdata[31:24]}, 7);
    chk("R10 req lags status", {31'd0, irq_req}, 0);
    @(negedge clk); #1 chk("R10 req asserted", {31'd0, irq_req}, 1);
    irq_in[7] = 1'b0; settle();
    chk("R10 req released", {31'd0, irq_req}, 0);
    wr(c0(7), 0);
  endtask

  task automatic t_level_low();
    wr(c0(50), 32'h3000_0000);
    settle(); chk_cs("R4 level low pending", 50);
    irq_in[50] = 1'b1; settle(); chk_cs("R4 level low idle", 63);
    wr(c0(50), 0); irq_in[50] = 1'b0;
  endtask

  task automatic t_rise();
    wr(c0(48), 32'h3300_0000);
    @(negedge clk); bus_addr = 12'h144;
    irq_in[48] = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R12 edge two edges", {24'd0, bus_rdata[31:24]}, 63);
    @(negedge clk); #1 chk("R12 edge three edges", {24'd0, bus_rdata[31:24]}, 48);
    irq_in[48] = 1'b0; settle();
    chk_cs("R5 rising latch holds", 48);
    wr(12'h0C0, 32'h0000_0000); settle();
    chk_cs("R6 clear without bit 8", 48);
    wr(12'h0C0, 32'h0000_0101); settle();
    chk_cs("R6 clear other source", 48);
    wr(12'h0C0, 32'h0000_0100); settle();
    chk_cs("R6 clear src48", 63);
    wr(c0(48), 0);
  endtask

  task automatic t_fall();
    wr(c0(49), 32'h3200_0000);
    irq_in[49] = 1'b1; settle();
    chk_cs("R5 falling ignores rise", 63);
    irq_in[49] = 1'b0; settle();
    chk_cs("R5 falling latched", 49);
    wr(12'h0C0, 32'h0000_0101); settle();
    chk_cs("R6 clear src49", 63);
    wr(c0(49), 0);
  endtask

  task automatic t_enable();
    irq_in[20] = 1'b1;
    wr(c0(20), 32'h1100_0000); settle(); chk_cs("R7 low enable bit only", 63);
    wr(c0(20), 32'h2100_0000); settle(); chk_cs("R7 high enable bit only", 63);
    wr(c0(20), 32'h3100_0000); settle(); chk_cs("R7 both enable bits", 20);
    wr(c0(20), 0); irq_in[20] = 1'b0; settle(); chk_cs("R7 disabled", 63);
  endtask

  task automatic t_prio();
    wr(c0(5), 32'h3100_0000); wr(c0(10), 32'h3100_0000); wr(c0(60), 32'h3100_0000);
    irq_in[60] = 1'b1; irq_in[10] = 1'b1; irq_in[5] = 1'b1; settle();
    chk_cs("R8 lowest of three", 5);
    irq_in[5] = 1'b0; settle(); chk_cs("R8 next lowest", 10);
    irq_in[10] = 1'b0; settle(); chk_cs("R8 last one", 60);
    irq_in[60] = 1'b0; settle(); chk_cs("R8 none pending", 63);
    wr(c0(5), 0); wr(c0(10), 0); wr(c0(60), 0);
  endtask

  task automatic t_det();
    wr(12'h004, 0);
    wr(c0(48), 32'h3300_0000); wr(c0(20), 32'h3100_0000);
    irq_in[20] = 1'b1; irq_in[48] = 1'b1; settle();
    irq_in[48] = 1'b0; settle();
    chk_cs("R9 gate off", 63);
    chk("R9 no request", {31'd0, irq_req}, 0);
    wr(12'h004, 1); settle(); chk_cs("R9 gate on level", 20);
    irq_in[20] = 1'b0; settle(); chk_cs("R9 edge not latched while off", 63);
    wr(c0(48), 0); wr(c0(20), 0);
  endtask

  task automatic t_pkt();
    wr(12'h444, 0);
    wr(c0(20), 32'h3100_0000); irq_in[20] = 1'b1; settle();
    chk_cs("R10 status with gate off", 20);
    chk("R10 request blocked", {31'd0, irq_req}, 0);
    wr(12'h444, 1); @(negedge clk);
    chk("R10 request after gate on", {31'd0, irq_req}, 1);
    irq_in[20] = 1'b0; wr(c0(20), 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(12'h084, 32'hFFFF_FFFF);
    rd(12'h084, v); chk("R11 mask readback", v, 32'hFFFF_FFFF);
    wr(c0(20), 32'h3100_0000); irq_in[20] = 1'b1; settle();
    chk_cs("R11 mask has no effect", 20);
    wr(12'h084, 0); irq_in[20] = 1'b0; wr(c0(20), 0);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    wr(12'h004, 1); wr(12'h444, 1);
    t_force();
    t_timing();
    t_level_low();
    t_rise();
    t_fall();
    t_enable();
    t_prio();
    t_det();
    t_pkt();
    t_mask();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got=timeout exp=completion");
    finish_up();
  end
endmodule